// File: doc/BRIEF.md
# Frame-Indexed Associative Page Translator

This block turns a virtual address into a physical address using a table that is indexed by physical frame, not by virtual page. Each physical frame owns one entry. The entry records which virtual page number currently lives in that frame, and a flag says whether the entry is in use. The table therefore grows with physical memory and does not depend on the size of the virtual address space.

On a lookup, the page-number part of the request is compared against every entry at once. The position of the matching entry is the frame number. That position, in binary, is placed above the untouched page offset to form the physical address.

Memory-management software uses a single write port to fill an entry when it hands a frame to a page, or to clear the entry when the frame is released. The result of each lookup is registered. Exactly one cycle after a request, one of two strobes rises: a physical-address strobe or a miss strobe.

Top module: `ipt_translate`

## Requirements
- R1: After reset, `pa_valid`, `miss` and `multi_hit` are low, and every entry is empty, so any lookup misses until an entry is written.
- R2: A request whose page number (the address bits above the offset) matches a valid entry raises `pa_valid` in the next cycle, with `miss` low and the binary index of that entry in the upper `pa_addr` bits.
- R3: The low `OFS_W` bits of `pa_addr` (12 by default, i.e. 4 KB pages) equal the offset bits of the request.
- R4: A request that matches no valid entry raises `miss` in the next cycle with `pa_valid` low; the two strobes are never high together.
- R5: An entry written with `wr_valid` = 0 never matches, whatever page number it holds.
- R6: When several valid entries match, the lowest index is reported and `multi_hit` is high with `pa_valid`; with a single match `multi_hit` is low.
- R7: In a cycle after one with `req_valid` low, both `pa_valid` and `miss` are low.
- R8: A write and a lookup in the same cycle: the lookup sees the table as it was before the write, and the write is visible from the next cycle on.
- R9: Rewriting a frame with a new page number replaces the old mapping; the old page number no longer matches that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one table entry |
| wr_frame | input | FRAME_W | Frame whose entry is written |
| wr_valid | input | 1 | 1 = frame holds a page, 0 = frame free |
| wr_vpn | input | VPN_W | Virtual page number stored in the entry |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VA_W | Virtual address to translate |
| pa_valid | output | 1 | Translation succeeded (one cycle after request) |
| pa_addr | output | PA_W | Frame index concatenated with offset |
| miss | output | 1 | No valid entry matched |
| multi_hit | output | 1 | More than one valid entry matched |

## Verification
The bench builds the block with 16 frames, a 20-bit virtual address and a 12-bit offset, which gives an 8-bit page number and a 16-bit physical address. With 16 frames, both the lowest and the highest frame index can be exercised. Duplicate mappings can be set up cheaply to test the multiple-match priority. A write and a lookup can be placed in the same cycle, and a page number stored in a freed entry can be probed to confirm that it does not match.

// File: rtl/ipt_pkg.sv
// Package: shared types for the frame-indexed translator.
// Assumes: nothing beyond IEEE 1800-2017.
package ipt_pkg;
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_kind_e;
endpackage

// File: rtl/ipt_entry_store.sv
// Module: ipt_entry_store
// Holds one entry per physical frame: an in-use flag and the virtual page
// number that occupies the frame. One write per cycle.
// Assumes: wr_frame < NUM_FRAMES; synchronous active-low reset clears flags.
module ipt_entry_store #(
    parameter int NUM_FRAMES = 64,
    parameter int VPN_W      = 20,
    localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [FRAME_W-1:0]               wr_frame,
    input  logic                             wr_valid,
    input  logic [VPN_W-1:0]                 wr_vpn,
    output logic [NUM_FRAMES-1:0]            ent_valid,
    output logic [NUM_FRAMES-1:0][VPN_W-1:0] ent_vpn
);
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_entry
        // Update this frame's entry when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_vpn[g]   <= '0;
            end else if (wr_en && (wr_frame == FRAME_W'(g))) begin
                ent_valid[g] <= wr_valid;
                ent_vpn[g]   <= wr_vpn;
            end
        end
    end
endmodule

// File: rtl/ipt_match_array.sv
// Module: ipt_match_array
// Compares the requested page number with every entry at once.
// Assumes: an entry whose flag is clear can never produce a match.
module ipt_match_array #(
    parameter int NUM_FRAMES = 64,
    parameter int VPN_W      = 20
) (
    input  logic [VPN_W-1:0]                 look_vpn,
    input  logic [NUM_FRAMES-1:0]            ent_valid,
    input  logic [NUM_FRAMES-1:0][VPN_W-1:0] ent_vpn,
    output logic [NUM_FRAMES-1:0]            match
);
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
        // One comparator per frame, gated by the entry's in-use flag.
        always_comb match[g] = ent_valid[g] && (ent_vpn[g] == look_vpn);
    end
endmodule

// File: rtl/ipt_prio_encoder.sv
// Module: ipt_prio_encoder
// Turns the match vector into a binary frame index, preferring the lowest
// set bit, and flags when two or more bits are set.
// Assumes: idx is meaningful only when any_hit is high.
module ipt_prio_encoder #(
    parameter int NUM_FRAMES = 64,
    localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [NUM_FRAMES-1:0] match,
    output logic                  any_hit,
    output logic                  several,
    output logic [FRAME_W-1:0]    idx
);
    // Scan from the top down so the lowest matching index is kept last.
    always_comb begin
        idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (match[i]) idx = FRAME_W'(i);
        end
    end

    // Detect any match, and more than one match by clearing the lowest bit.
    always_comb begin
        any_hit = |match;
        several = |(match & (match - NUM_FRAMES'(1)));
    end
endmodule

// File: rtl/ipt_translate.sv
// Module: ipt_translate (top)
// Frame-indexed translation: associative search of the per-frame table,
// result registered one cycle after the request.
// Assumes: offset width < address width; lookups read the table before a
// same-cycle write takes effect.
module ipt_translate
    import ipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int OFS_W      = 12,
    parameter int NUM_FRAMES = 64,
    localparam int VPN_W     = VA_W - OFS_W,
    localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int PA_W      = FRAME_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               pa_valid,
    output logic [PA_W-1:0]    pa_addr,
    output logic               miss,
    output logic               multi_hit
);
    logic [NUM_FRAMES-1:0]            ent_valid;
    logic [NUM_FRAMES-1:0][VPN_W-1:0] ent_vpn;
    logic [NUM_FRAMES-1:0]            match;
    logic                             any_hit;
    logic                             several;
    logic [FRAME_W-1:0]               hit_idx;
    rsp_kind_e                        kind_d;

    ipt_entry_store #(.NUM_FRAMES(NUM_FRAMES), .VPN_W(VPN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_frame (wr_frame),
        .wr_valid (wr_valid),
        .wr_vpn   (wr_vpn),
        .ent_valid(ent_valid),
        .ent_vpn  (ent_vpn)
    );

    ipt_match_array #(.NUM_FRAMES(NUM_FRAMES), .VPN_W(VPN_W)) u_match (
        .look_vpn (req_vaddr[VA_W-1:OFS_W]),
        .ent_valid(ent_valid),
        .ent_vpn  (ent_vpn),
        .match    (match)
    );

    ipt_prio_encoder #(.NUM_FRAMES(NUM_FRAMES)) u_enc (
        .match  (match),
        .any_hit(any_hit),
        .several(several),
        .idx    (hit_idx)
    );

    // Classify this cycle's request as hit, miss or nothing.
    always_comb begin
        if (!req_valid)   kind_d = RSP_NONE;
        else if (any_hit) kind_d = RSP_HIT;
        else              kind_d = RSP_MISS;
    end

    // Register the translation result and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_valid  <= 1'b0;
            miss      <= 1'b0;
            multi_hit <= 1'b0;
            pa_addr   <= '0;
        end else begin
            pa_valid  <= (kind_d == RSP_HIT);
            miss      <= (kind_d == RSP_MISS);
            multi_hit <= (kind_d == RSP_HIT) && several;
            pa_addr   <= (kind_d == RSP_HIT) ? {hit_idx, req_vaddr[OFS_W-1:0]} : '0;
        end
    end
endmodule

// File: rtl/ipt_translate_checker.sv
// Module: ipt_translate_checker
// Temporal properties of the translator's ports, attached by bind.
// Assumes: same parameters as the bound instance.
module ipt_translate_checker #(
    parameter int VA_W       = 32,
    parameter int OFS_W      = 12,
    parameter int PA_W       = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            pa_valid,
    input logic [PA_W-1:0] pa_addr,
    input logic            miss,
    input logic            multi_hit
);
    // R4: hit and miss strobes are exclusive.
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_valid && miss));

    // R7: a request yields exactly one strobe in the next cycle.
    assert_req_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (pa_valid || miss));

    // R7: no request, no strobe in the next cycle.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!pa_valid && !miss));

    // R3: offset passes through on a hit.
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!pa_valid || (pa_addr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))));

    // R6: the multiple-match flag only accompanies a hit.
    assert_multi_with_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> pa_valid);
endmodule

bind ipt_translate ipt_translate_checker #(
    .VA_W (VA_W),
    .OFS_W(OFS_W),
    .PA_W (PA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_vaddr(req_vaddr),
    .pa_valid (pa_valid),
    .pa_addr  (pa_addr),
    .miss     (miss),
    .multi_hit(multi_hit)
);

// File: tb/tb_ipt_translate.sv
`timescale 1ns/1ps
module tb_ipt_translate;
    localparam int VA_W    = 20;
    localparam int OFS_W   = 12;
    localparam int NFR     = 16;
    localparam int VPN_W   = VA_W - OFS_W;
    localparam int FRAME_W = 4;
    localparam int PA_W    = FRAME_W + OFS_W;

    typedef struct {
        bit              hit;
        bit              multi;
        logic [PA_W-1:0] addr;
        int              due;
        string           tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [FRAME_W-1:0] wr_frame = '0;
    logic               wr_valid = 1'b0;
    logic [VPN_W-1:0]   wr_vpn = '0;
    logic               req_valid = 1'b0;
    logic [VA_W-1:0]    req_vaddr = '0;
    logic               pa_valid;
    logic [PA_W-1:0]    pa_addr;
    logic               miss;
    logic               multi_hit;

    int   n_run = 0;
    int   n_fail = 0;
    int   cyc = 0;
    exp_t sb[$];
    bit              m_valid [NFR];
    logic [VPN_W-1:0] m_vpn  [NFR];

    ipt_translate #(.VA_W(VA_W), .OFS_W(OFS_W), .NUM_FRAMES(NFR)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_frame(wr_frame),
        .wr_valid(wr_valid), .wr_vpn(wr_vpn), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .pa_valid(pa_valid), .pa_addr(pa_addr),
        .miss(miss), .multi_hit(multi_hit)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Drive one cycle: optional write, optional lookup; expected from model before the write (R8).
    task automatic step(input bit w, input int f, input bit wv, input int vpn,
                        input bit r, input int va, input string tag);
        exp_t e;
        int   cnt;
        @(negedge clk);
        wr_en = w; wr_frame = FRAME_W'(f); wr_valid = wv; wr_vpn = VPN_W'(vpn);
        req_valid = r; req_vaddr = VA_W'(va);
        if (r) begin
            e.hit = 0; e.multi = 0; e.addr = '0; e.due = cyc + 1; e.tag = tag; cnt = 0;
            for (int i = NFR - 1; i >= 0; i--) begin
                if (m_valid[i] && m_vpn[i] == VPN_W'(va >> OFS_W)) begin
                    e.hit = 1; cnt++;
                    e.addr = {FRAME_W'(i), OFS_W'(va)};
                end
            end
            e.multi = (cnt > 1);
            sb.push_back(e);
        end
        if (w) begin
            m_valid[f] = wv;
            m_vpn[f]   = VPN_W'(vpn);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, "idle");
    endtask

    // Monitor: pop and compare each result in the cycle it is due.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (pa_valid !== e.hit || miss !== !e.hit || multi_hit !== e.multi ||
                    (e.hit && pa_addr !== e.addr)) begin
                    n_fail++;
                    $display("FAIL %s: got pv=%0b miss=%0b multi=%0b pa=%h, exp pv=%0b miss=%0b multi=%0b pa=%h",
                             e.tag, pa_valid, miss, multi_hit, pa_addr,
                             e.hit, !e.hit, e.multi, e.addr);
                end
            end else if (pa_valid || miss) begin
                n_run++; n_fail++;
                $display("FAIL R7: got pv=%0b miss=%0b, exp pv=0 miss=0", pa_valid, miss);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NFR; i++) begin m_valid[i] = 0; m_vpn[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (pa_valid !== 0 || miss !== 0 || multi_hit !== 0) begin
            n_fail++;
            $display("FAIL R1: got pv=%0b miss=%0b multi=%0b, exp 0 0 0", pa_valid, miss, multi_hit);
        end
        rst_n = 1'b1;
        step(0, 0, 0, 0, 1, 'h00123, "R1 empty table misses");
        step(0, 0, 0, 0, 1, 'h77000, "R4 miss");
        step(1, 5, 1, 'h12, 0, 0, "write");
        step(0, 0, 0, 0, 1, 'h12abc, "R2 R3 hit frame 5");
        step(1, 0, 1, 'h34, 1, 'h34000, "R8 same-cycle write not seen");
        step(0, 0, 0, 0, 1, 'h34fff, "R8 write seen next cycle");
        step(1, 9, 1, 'h12, 0, 0, "write duplicate");
        step(0, 0, 0, 0, 1, 'h12001, "R6 lowest index and multi");
        step(1, 5, 0, 'h12, 0, 0, "free frame 5");
        step(0, 0, 0, 0, 1, 'h12777, "R5 R6 single match after free");
        step(1, 15, 1, 'hff, 0, 0, "write top frame");
        step(0, 0, 0, 0, 1, 'hff123, "R2 top index");
        step(1, 15, 1, 'hee, 0, 0, "rewrite top frame");
        step(0, 0, 0, 0, 1, 'hff000, "R9 old page gone");
        step(0, 0, 0, 0, 1, 'hee456, "R9 new page hits");
        step(1, 0, 0, 'h34, 0, 0, "free frame 0");
        step(0, 0, 0, 0, 1, 'h34000, "R5 freed entry ignored");
        idle(3);  // R7: monitor flags any strobe here
        for (int i = 1; i < 8; i++) step(1, i, 1, 'h40 + i, 0, 0, "fill");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, (('h40 + i) << OFS_W) | (i * 'h111), "R2 R3 R4 back-to-back");
        idle(3);
        if (sb.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R7: got %0d pending results, exp 0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule